// File: doc/BRIEF.md
# Clock-Stop SPI Master Serializer

This block moves one word over a four-wire serial link as the bus master. A host places a transmit word, a word length and a divider value on the inputs and pulses start. The block pulls the active-low select line, waits one full serial-clock period, then runs a gated serial clock derived from the system clock. On every rising serial-clock edge it samples the input data line. On every falling edge it moves the next transmit bit onto the output data line. When the word is complete it releases the select line and raises a one-cycle done pulse. The received word is available on the cycle of that pulse.

The serial clock rests low whenever no word is moving. Its period is (1 + divider) system clocks. An even divider gives a high phase one clock longer than the low phase. The output data line has its own drive enable, so the pin can be floated at the start and end of each frame. The word length is set per transfer, from 1 up to `MAX_BITS` bits. Divider, length and transmit word are captured when the start pulse is accepted.

Top module: `spi_cs_master`

## Requirements
- R1: While reset is held and after it is released, select is high, the serial clock is low, the data drive enable is low, and busy and done are low.
- R2: With an effective divider d that is even, each serial-clock period is d+1 system clocks: the clock is high for d/2+1 clocks and low for d/2 clocks.
- R3: With an odd effective divider d, the high and low phases each last (d+1)/2 system clocks.
- R4: A divider input of 0 produces exactly the timing of a divider of 1.
- R5: Select falls on the system-clock edge that accepts start. The first rising serial-clock edge comes one full serial period (d+1 clocks) later.
- R6: Transmit bits leave most significant first, from bit n-1 down to bit 0, where n = length field + 1. The first bit is driven one high-phase duration after select falls. Each later bit changes on a falling serial-clock edge.
- R7: The input data line is sampled at the system-clock edge where the serial clock rises. The n samples appear in bits n-1..0 of the receive word, first sample in bit n-1, and all higher bits are zero.
- R8: The drive enable drops on the falling serial-clock edge that ends the last bit. Select stays low for one low-phase duration after that edge, then returns high.
- R9: Done is high for exactly one system clock, on the cycle select returns high. Busy is high from the accepting edge up to that cycle. The receive word is valid when done is high.
- R10: A start pulse, and any change of divider, length or transmit word, while busy leaves the running frame unchanged.
- R11: The serial clock stays low whenever select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W | Bit-clock divider value (0 acts as 1) |
| len_i | input | LEN_W | Word length minus one |
| tx_data_i | input | MAX_BITS | Transmit word, right-aligned |
| start_i | input | 1 | Start request, taken only when idle |
| rx_data_o | output | MAX_BITS | Received word, right-aligned |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| sclk_o | output | 1 | Serial clock, idles low |
| ss_n_o | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Drive enable for serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The hardest part to observe from the ports is the exact sampling instant of the input line. A wrong sample a cycle early or late still yields a plausible word if the line is steady. The bench therefore drives the correct bit only in the single system cycle before each rising serial edge, and drives its inverse in the cycle before that. Any skew of the sample point then corrupts the received word. The frame is also compared cycle by cycle against a waveform computed from the divider, across even, odd, zero and one-bit cases. A start pulse with altered inputs is injected mid-frame to show the running frame is not disturbed.

// File: rtl/spi_cs_pkg.sv
// Package: shared types for the clock-stop SPI master.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package spi_cs_pkg;

    // Frame phases: idle, two lead halves, then alternating clock phases.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD_A = 3'd1,
        ST_LEAD_B = 3'd2,
        ST_HIGH   = 3'd3,
        ST_LOW    = 3'd4
    } xfer_state_t;

endpackage

// File: rtl/spi_cs_phase.sv
// Module: spi_cs_phase
// Turns a divider value into high- and low-phase lengths in system clocks.
// A zero divider is clamped to one. The value is latched when a frame is
// accepted. During the accepting cycle the live input is used, so the
// sequencer can load its first timer value at once.
// Assumes DIV_W >= 2.
module spi_cs_phase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] h_len_o,
    output logic [DIV_W-1:0] l_len_o
);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_sel;

    // Clamp zero to one so every phase is at least one clock.
    always_comb begin
        div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    end

    // Hold the divider of the running frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
        end else if (accept_i) begin
            div_q <= div_eff;
        end
    end

    // High phase is floor(d/2)+1; low phase is floor(d/2) plus the odd bit.
    always_comb begin
        div_sel = accept_i ? div_eff : div_q;
        h_len_o = (div_sel >> 1) + DIV_W'(1);
        l_len_o = (div_sel >> 1) + {{(DIV_W-1){1'b0}}, div_sel[0]};
    end

endmodule

// File: rtl/spi_cs_seq.sv
// Module: spi_cs_seq
// Frame sequencer. It walks lead-A (high-phase length, line floating),
// then lead-B (low-phase length, first bit driven), then n high/low
// pairs. It produces sample, shift and finish strobes at phase ends.
// Assumes phase lengths are >= 1 and held stable while a frame runs.
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DIV_W-1:0] h_len_i,
    input  logic [DIV_W-1:0] l_len_i,
    output logic             accept_o,
    output xfer_state_t      state_o,
    output logic             more_o,
    output logic             sample_o,
    output logic             shift_o,
    output logic             finish_o
);

    xfer_state_t      state_q;
    logic [DIV_W-1:0] tmr_q;
    logic [LEN_W-1:0] bits_left_q;
    logic             phase_end;

    // Decode the strobes that the shifter and outputs depend on.
    always_comb begin
        accept_o  = (state_q == ST_IDLE) && start_i;
        phase_end = (state_q != ST_IDLE) && (tmr_q == '0);
        more_o    = (bits_left_q != '0);
        sample_o  = phase_end && ((state_q == ST_LEAD_B) ||
                                  ((state_q == ST_LOW) && more_o));
        shift_o   = phase_end && (state_q == ST_HIGH) && more_o;
        finish_o  = phase_end && (state_q == ST_LOW) && !more_o;
        state_o   = state_q;
    end

    // Advance the phase timer and state, and count the bits still to move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tmr_q       <= '0;
            bits_left_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        state_q     <= ST_LEAD_A;
                        tmr_q       <= h_len_i - DIV_W'(1);
                        bits_left_q <= len_i;
                    end
                end
                ST_LEAD_A: begin
                    if (phase_end) begin
                        state_q <= ST_LEAD_B;
                        tmr_q   <= l_len_i - DIV_W'(1);
                    end else begin
                        tmr_q <= tmr_q - DIV_W'(1);
                    end
                end
                ST_LEAD_B: begin
                    if (phase_end) begin
                        state_q <= ST_HIGH;
                        tmr_q   <= h_len_i - DIV_W'(1);
                    end else begin
                        tmr_q <= tmr_q - DIV_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        state_q <= ST_LOW;
                        tmr_q   <= l_len_i - DIV_W'(1);
                    end else begin
                        tmr_q <= tmr_q - DIV_W'(1);
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        if (more_o) begin
                            state_q     <= ST_HIGH;
                            tmr_q       <= h_len_i - DIV_W'(1);
                            bits_left_q <= bits_left_q - LEN_W'(1);
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        tmr_q <= tmr_q - DIV_W'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_HIGH_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH) |-> (tmr_q < h_len_i)); // R2

    AST_LOW_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW) |-> (tmr_q < l_len_i)); // R3

endmodule

// File: rtl/spi_cs_shift.sv
// Module: spi_cs_shift
// Transmit and receive shift registers. The transmit word is loaded
// left-aligned so its bit n-1 sits at the top and drives the line. The
// receive register is cleared on load and fills from the bottom. On finish
// the receive word is published with a one-cycle done pulse.
// Assumes MAX_BITS >= 2 and a power of two (len never exceeds MAX_BITS-1).
module spi_cs_shift #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [MAX_BITS-1:0] tx_i,
    input  logic                shift_i,
    input  logic                sample_i,
    input  logic                finish_i,
    input  logic                miso_i,
    output logic                mosi_o,
    output logic [MAX_BITS-1:0] rx_o,
    output logic                done_o
);

    localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(MAX_BITS - 1);

    logic [MAX_BITS-1:0] tx_sh;
    logic [MAX_BITS-1:0] rx_sh;

    // Load the transmit word, then move it up one place per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load_i) begin
            tx_sh <= tx_i << (TOP_IDX - len_i);
        end else if (shift_i) begin
            tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
        end
    end

    // Clear on load, then collect one input bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (load_i) begin
            rx_sh <= '0;
        end else if (sample_i) begin
            rx_sh <= {rx_sh[MAX_BITS-2:0], miso_i};
        end
    end

    // Publish the received word with a single-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_o   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= finish_i;
            if (finish_i) begin
                rx_o <= rx_sh;
            end
        end
    end

    // The current top bit is the line value.
    always_comb begin
        mosi_o = tx_sh[MAX_BITS-1];
    end

    AST_NO_SHIFT_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_i && sample_i)); // R6

    AST_RX_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !load_i) |=> (!done_o || $past(finish_i))); // R9

endmodule

// File: rtl/spi_cs_master.sv
// Module: spi_cs_master (top)
// Clock-stop SPI master: active-low select, serial clock idling low,
// data out on falling edges, data in on rising edges, MSB first.
// Assumes synchronous active-low reset and MAX_BITS a power of two >= 2.
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [MAX_BITS-1:0] tx_data_i,
    input  logic                start_i,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                sclk_o,
    output logic                ss_n_o,
    output logic                mosi_o,
    output logic                mosi_oe_o,
    input  logic                miso_i
);

    logic             accept;
    logic [DIV_W-1:0] h_len;
    logic [DIV_W-1:0] l_len;
    xfer_state_t      state;
    logic             more;
    logic             sample;
    logic             shift;
    logic             finish;

    spi_cs_phase #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .div_i    (div_i),
        .h_len_o  (h_len),
        .l_len_o  (l_len)
    );

    spi_cs_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .len_i    (len_i),
        .h_len_i  (h_len),
        .l_len_i  (l_len),
        .accept_o (accept),
        .state_o  (state),
        .more_o   (more),
        .sample_o (sample),
        .shift_o  (shift),
        .finish_o (finish)
    );

    spi_cs_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .len_i    (len_i),
        .tx_i     (tx_data_i),
        .shift_i  (shift),
        .sample_i (sample),
        .finish_i (finish),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .rx_o     (rx_data_o),
        .done_o   (done_o)
    );

    // Pin decode from the registered frame state.
    always_comb begin
        ss_n_o    = (state == ST_IDLE);
        busy_o    = (state != ST_IDLE);
        sclk_o    = (state == ST_HIGH);
        mosi_oe_o = (state == ST_LEAD_B) || (state == ST_HIGH) ||
                    ((state == ST_LOW) && more);
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sclk_o); // R11

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !mosi_oe_o); // R8

    AST_SS_HELD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !ss_n_o); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AT_SS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n_o) |-> done_o); // R9

endmodule

// File: tb/tb_spi_cs_master.sv
// Directed bench: each task runs one scenario and checks its own results
// against a waveform computed from the requirements.
module tb_spi_cs_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_i = '0;
    logic [3:0]  len_i = '0;
    logic [15:0] tx_data_i = '0;
    logic        start_i = 1'b0;
    logic [15:0] rx_data_o;
    logic        busy_o, done_o, sclk_o, ss_n_o, mosi_o, mosi_oe_o;
    logic        miso_i = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_cs_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_i),
        .len_i     (len_i),
        .tx_data_i (tx_data_i),
        .start_i   (start_i),
        .rx_data_o (rx_data_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .sclk_o    (sclk_o),
        .ss_n_o    (ss_n_o),
        .mosi_o    (mosi_o),
        .mosi_oe_o (mosi_oe_o),
        .miso_i    (miso_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ss_n_o == 1'b1, "R1 select high in reset", ss_n_o, 1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(ss_n_o == 1'b1, "R1 select high", ss_n_o, 1);
        check(sclk_o == 1'b0, "R1/R11 clock low", sclk_o, 0);
        check(mosi_oe_o == 1'b0, "R1 drive off", mosi_oe_o, 0);
        check(busy_o == 1'b0, "R1 busy low", busy_o, 0);
        check(done_o == 1'b0, "R1 done low", done_o, 0);
    endtask

    // One frame; poke >= 0 injects a changed start request at that cycle.
    task automatic run_xfer(input int div, input int len, input logic [15:0] tx,
                            input logic [15:0] rxpat, input int poke, input string ttag);
        int d = (div == 0) ? 1 : div;
        int h = d / 2 + 1;
        int l = d / 2 + d % 2;
        int t = h + l;
        int n = len + 1;
        int fin = (n + 1) * t;
        int e_ss = 0, e_sclk = 0, e_oe = 0, e_mosi = 0, e_busy = 0, e_done = 0;
        int a_ss = 0, a_sclk = 0, a_oe = 0, a_mosi = 0;
        logic [15:0] mask = 16'((32'h1 << n) - 1);
        @(negedge clk);
        div_i = 8'(div); len_i = 4'(len); tx_data_i = tx; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j <= fin; j++) begin
            logic x_ss, x_sclk, x_oe, x_mosi;
            int nj;
            x_ss = 1'b0; x_sclk = 1'b0; x_oe = 1'b0; x_mosi = 1'b0;
            if (j >= fin) begin
                x_ss = 1'b1;
            end else if (j < h) begin
                x_oe = 1'b0;
            end else if (j < t) begin
                x_oe = 1'b1; x_mosi = tx[n-1];
            end else begin
                int k = (j - t) / t;
                int p = (j - t) % t;
                if (p < h) begin
                    x_sclk = 1'b1; x_oe = 1'b1; x_mosi = tx[n-1-k];
                end else if (k != n - 1) begin
                    x_oe = 1'b1; x_mosi = tx[n-2-k];
                end
            end
            if (ss_n_o !== x_ss) begin e_ss++; a_ss = j; end
            if (sclk_o !== x_sclk) begin e_sclk++; a_sclk = j; end
            if (mosi_oe_o !== x_oe) begin e_oe++; a_oe = j; end
            if (x_oe && (mosi_o !== x_mosi)) begin e_mosi++; a_mosi = j; end
            if (busy_o !== (j < fin)) e_busy++;
            if (j < fin && done_o !== 1'b0) e_done++;
            if (j == fin) begin
                check(done_o == 1'b1, "R9 done at frame end", done_o, 1);
                check((rx_data_o & ~mask) == 16'h0 && (rx_data_o & mask) == (rxpat & mask),
                      "R7 received word", rx_data_o, rxpat & mask);
            end
            // Drive the right bit only in the cycle before each rising edge.
            nj = j + 1;
            if (nj >= t && (nj - t) % t == 0 && (nj - t) / t < n)
                miso_i = rxpat[n-1-(nj-t)/t];
            else if (nj + 1 >= t && (nj + 1 - t) % t == 0 && (nj + 1 - t) / t < n)
                miso_i = ~rxpat[n-1-(nj+1-t)/t];
            else
                miso_i = j[0];
            if (j == poke) begin
                start_i = 1'b1; tx_data_i = ~tx; div_i = 8'(div + 3); len_i = 4'(len ^ 1);
            end else begin
                start_i = 1'b0;
            end
            if (j < fin) @(negedge clk);
        end
        check(e_ss == 0, "R5/R8 select timing", a_ss, 0);
        check(e_sclk == 0, ttag, a_sclk, 0);
        check(e_oe == 0, "R8/R6 drive enable timing", a_oe, 0);
        check(e_mosi == 0, "R6 data out order", a_mosi, 0);
        check(e_busy == 0, "R9 busy span", e_busy, 0);
        check(e_done == 0, "R9 no early done", e_done, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done lasts one cycle", done_o, 0);
        check(sclk_o == 1'b0 && ss_n_o == 1'b1, "R11 idle clock low", sclk_o, 0);
        if (poke >= 0)
            check(e_ss + e_sclk + e_oe + e_mosi + e_busy + e_done == 0,
                  "R10 frame unaffected by start while busy",
                  e_ss + e_sclk + e_oe + e_mosi, 0);
    endtask

    task automatic t_even_div();   run_xfer(4, 7, 16'h00A5, 16'h003C, -1, "R2 even clock split"); endtask
    task automatic t_odd_div();    run_xfer(5, 15, 16'hC3A1, 16'h5E69, -1, "R3 odd clock split"); endtask
    task automatic t_zero_div();   run_xfer(0, 3, 16'h0009, 16'h0006, -1, "R4 zero divider"); endtask
    task automatic t_single_bit(); run_xfer(1, 0, 16'h0001, 16'h0001, -1, "R3 one-bit frame"); endtask
    task automatic t_busy_start(); run_xfer(2, 5, 16'h002D, 16'h0033, 7, "R2 clock with start while busy"); endtask
    task automatic t_wide_even();  run_xfer(10, 11, 16'h0B6E, 16'h0A5F, -1, "R2 wide even split"); endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run hung actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_even_div();
        t_odd_div();
        t_zero_div();
        t_single_bit();
        t_busy_start();
        t_wide_even();
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule